// File: doc/BRIEF.md
# Dual Alarm Interrupt Controller

This block sits inside a real-time-clock register file and turns two time-of-day alarm events into interrupt requests. An external comparator delivers a one-cycle match pulse per alarm. Each pulse sets a sticky request flag. The flag stays set until software touches that alarm's register group. The register file reports such an access to this block as a strobe for the alarm 0 group or for the alarm 1 group.

A control write loads two enable bits and one routing bit. When the routing bit is set, each alarm owns its own active-low interrupt pin. When it is clear, both alarms share pin 0 and pin 1 stays idle (high). Both pins are registered. The two flags can be read back in an 8-bit status byte.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: With the routing bit set (ctl_wdata_i[2]=1), irq0_n_o goes low only for flag 0 with enable 0 set, and irq1_n_o goes low only for flag 1 with enable 1 set.
- R2: With the routing bit clear, irq0_n_o goes low for any set flag whose enable is set, and irq1_n_o stays high.
- R3: An enable bit at 0 (enable 0 in ctl_wdata_i[0], enable 1 in ctl_wdata_i[1]) still lets its flag set, but that flag produces no interrupt on either pin.
- R4: Flag 0 sets on match0_i and clears on acc0_i. It holds in every other cycle, and acc1_i has no effect on it.
- R5: Flag 1 sets on match1_i and clears on acc1_i. It holds in every other cycle, and acc0_i has no effect on it.
- R6: When a match pulse and an access strobe for the same alarm arrive in one cycle, the flag ends up set.
- R7: status_o carries flag 1 in bit 1 and flag 0 in bit 0. Bits 7 to 2 always read 0.
- R8: A status write strobe (stat_we_i) changes neither flag nor either pin.
- R9: After reset, both flags, both enables and the routing bit are 0, status_o is 0 and both pins are high.
- R10: A pin updates on the clock edge after the edge that changes a flag, an enable or the routing bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| match0_i | input | 1 | Alarm 0 time-match pulse |
| match1_i | input | 1 | Alarm 1 time-match pulse |
| acc0_i | input | 1 | Read or write of any alarm 0 register |
| acc1_i | input | 1 | Read or write of any alarm 1 register |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 3 | Control data: [0] enable 0, [1] enable 1, [2] routing (1 = separate pins) |
| stat_we_i | input | 1 | Write strobe to the read-only status register |
| status_o | output | 8 | Status byte: [1] flag 1, [0] flag 0 |
| irq0_n_o | output | 1 | Interrupt pin 0, active low |
| irq1_n_o | output | 1 | Interrupt pin 1, active low |

## Verification
A wrong flag shows up in status_o on the edge that should have changed it. It reaches the pins one edge later. A wrong enable or routing bit is only visible through the pins, and only while a flag is set. For that reason, each routing and enable pattern is applied together with set flags and checked two edges after the match pulse. The same-cycle set and clear case and the ignored status write are each driven on their own and then checked in status_o and on both pins.

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl #(
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              match0_i,
  input  logic              match1_i,
  input  logic              acc0_i,
  input  logic              acc1_i,
  input  logic              ctl_we_i,
  input  logic [2:0]        ctl_wdata_i,
  input  logic              stat_we_i,
  output logic [STAT_W-1:0] status_o,
  output logic              irq0_n_o,
  output logic              irq1_n_o
);

  logic flag0_q, flag1_q;
  logic en0_q, en1_q, route_q;
  logic req0, req1;
  logic unused_stat_we;

  assign unused_stat_we = stat_we_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag0_q <= 1'b0;
      flag1_q <= 1'b0;
    end else begin
      if (match0_i)    flag0_q <= 1'b1;
      else if (acc0_i) flag0_q <= 1'b0;
      if (match1_i)    flag1_q <= 1'b1;
      else if (acc1_i) flag1_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en0_q   <= 1'b0;
      en1_q   <= 1'b0;
      route_q <= 1'b0;
    end else if (ctl_we_i) begin
      en0_q   <= ctl_wdata_i[0];
      en1_q   <= ctl_wdata_i[1];
      route_q <= ctl_wdata_i[2];
    end
  end

  assign req0 = (en0_q & flag0_q) | (~route_q & en1_q & flag1_q);
  assign req1 = route_q & en1_q & flag1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq0_n_o <= 1'b1;
      irq1_n_o <= 1'b1;
    end else begin
      irq0_n_o <= ~req0;
      irq1_n_o <= ~req1;
    end
  end

  assign status_o = {{(STAT_W-2){1'b0}}, flag1_q, flag0_q};

endmodule

// File: rtl/alarm_irq_ctrl_chk.sv
module alarm_irq_ctrl_chk #(
  parameter int STAT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              match0_i,
  input logic              match1_i,
  input logic              acc0_i,
  input logic              acc1_i,
  input logic              stat_we_i,
  input logic [STAT_W-1:0] status_o,
  input logic              irq0_n_o,
  input logic              irq1_n_o,
  input logic              en0_q,
  input logic              en1_q,
  input logic              route_q
);

  // R4 R6
  flag0_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match0_i |=> status_o[0]);

  // R4
  flag0_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc0_i && !match0_i) |=> !status_o[0]);

  // R5 R6
  flag1_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match1_i |=> status_o[1]);

  // R5
  flag1_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc1_i && !match1_i) |=> !status_o[1]);

  // R2
  pin1_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !route_q |=> irq1_n_o);

  // R1
  sep_pin0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (route_q && !en0_q) |=> irq0_n_o);

  // R3
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en0_q && !en1_q) |=> (irq0_n_o && irq1_n_o));

  // R10
  pin0_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en0_q && status_o[0]) |=> !irq0_n_o);

  // R8
  stat_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_we_i && !acc0_i && !acc1_i && !match0_i && !match1_i) |=> $stable(status_o[1:0]));

  always @(posedge clk) begin
    if (rst_n) begin
      // R7
      upper_zero_chk: assert (status_o[STAT_W-1:2] == '0);
    end
  end

endmodule

bind alarm_irq_ctrl alarm_irq_ctrl_chk #(.STAT_W(STAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .match0_i(match0_i), .match1_i(match1_i),
  .acc0_i(acc0_i), .acc1_i(acc1_i), .stat_we_i(stat_we_i),
  .status_o(status_o), .irq0_n_o(irq0_n_o), .irq1_n_o(irq1_n_o),
  .en0_q(en0_q), .en1_q(en1_q), .route_q(route_q)
);

// File: tb/tb_alarm_irq_ctrl.sv
module tb_alarm_irq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic match0_i = 0, match1_i = 0, acc0_i = 0, acc1_i = 0;
  logic ctl_we_i = 0, stat_we_i = 0;
  logic [2:0] ctl_wdata_i = '0;
  logic [7:0] status_o;
  logic irq0_n_o, irq1_n_o;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  alarm_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .match0_i(match0_i), .match1_i(match1_i),
    .acc0_i(acc0_i), .acc1_i(acc1_i), .ctl_we_i(ctl_we_i),
    .ctl_wdata_i(ctl_wdata_i), .stat_we_i(stat_we_i),
    .status_o(status_o), .irq0_n_o(irq0_n_o), .irq1_n_o(irq1_n_o)
  );

  // vector: {ctl[2:0], m0, m1, exp_status[1:0], exp_irq0_n, exp_irq1_n}
  localparam logic [8:0] VEC [10] = '{
    {3'b111, 1'b1, 1'b0, 2'b01, 1'b0, 1'b1},  // R1
    {3'b111, 1'b0, 1'b1, 2'b10, 1'b1, 1'b0},  // R1
    {3'b111, 1'b1, 1'b1, 2'b11, 1'b0, 1'b0},  // R1
    {3'b011, 1'b0, 1'b1, 2'b10, 1'b0, 1'b1},  // R2
    {3'b011, 1'b1, 1'b0, 2'b01, 1'b0, 1'b1},  // R2
    {3'b011, 1'b1, 1'b1, 2'b11, 1'b0, 1'b1},  // R2
    {3'b110, 1'b1, 1'b0, 2'b01, 1'b1, 1'b1},  // R3
    {3'b101, 1'b0, 1'b1, 2'b10, 1'b1, 1'b1},  // R3
    {3'b000, 1'b1, 1'b1, 2'b11, 1'b1, 1'b1},  // R3
    {3'b010, 1'b1, 1'b0, 2'b01, 1'b1, 1'b1}   // R3
  };

  task automatic chk(input string tag, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic [2:0] cw, input logic m0, input logic m1,
                     input logic a0, input logic a1, input logic sw);
    ctl_we_i = we; ctl_wdata_i = cw; match0_i = m0; match1_i = m1;
    acc0_i = a0; acc1_i = a1; stat_we_i = sw;
    @(posedge clk);
    #1;
    ctl_we_i = 0; ctl_wdata_i = '0; match0_i = 0; match1_i = 0;
    acc0_i = 0; acc1_i = 0; stat_we_i = 0;
  endtask

  function automatic logic [9:0] obs();
    return {status_o, irq0_n_o, irq1_n_o};
  endfunction

  initial begin
    #(4 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual running expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    chk("R9 reset", obs(), {8'h00, 1'b1, 1'b1});
    rst_n = 1'b1;
    cyc(0, 3'b000, 0, 0, 0, 0, 0);
    chk("R9 after release", obs(), {8'h00, 1'b1, 1'b1});

    for (int i = 0; i < 10; i++) begin
      cyc(0, 3'b000, 0, 0, 1, 1, 0);
      cyc(1, VEC[i][8:6], 0, 0, 0, 0, 0);
      cyc(0, 3'b000, VEC[i][5], VEC[i][4], 0, 0, 0);
      cyc(0, 3'b000, 0, 0, 0, 0, 0);
      chk($sformatf("R1 R2 R3 vector %0d", i), obs(),
          {6'b0, VEC[i][3:2], VEC[i][1], VEC[i][0]});
    end

    // R4: hold, foreign access, own access
    cyc(0, 3'b000, 0, 0, 1, 1, 0);
    cyc(1, 3'b111, 0, 0, 0, 0, 0);
    cyc(0, 3'b000, 1, 0, 0, 0, 0);
    // R10: flag visible, pin not yet
    chk("R10 pin after flag", obs(), {8'h01, 1'b1, 1'b1});
    cyc(0, 3'b000, 0, 0, 0, 0, 0);
    chk("R10 pin one edge later", obs(), {8'h01, 1'b0, 1'b1});
    repeat (3) cyc(0, 3'b000, 0, 0, 0, 0, 0);
    chk("R4 flag holds", obs(), {8'h01, 1'b0, 1'b1});
    cyc(0, 3'b000, 0, 0, 0, 1, 0);
    chk("R4 acc1 ignored by flag 0", obs(), {8'h01, 1'b0, 1'b1});
    cyc(0, 3'b000, 0, 0, 1, 0, 0);
    chk("R4 acc0 clears", obs(), {8'h00, 1'b0, 1'b1});
    cyc(0, 3'b000, 0, 0, 0, 0, 0);
    chk("R10 pin releases", obs(), {8'h00, 1'b1, 1'b1});

    // R5
    cyc(0, 3'b000, 0, 1, 0, 0, 0);
    cyc(0, 3'b000, 0, 0, 1, 0, 0);
    chk("R5 acc0 ignored by flag 1", obs(), {8'h02, 1'b1, 1'b0});
    cyc(0, 3'b000, 0, 0, 0, 1, 0);
    chk("R5 acc1 clears", obs(), {8'h00, 1'b1, 1'b0});

    // R6 set wins
    cyc(0, 3'b000, 1, 1, 1, 1, 0);
    cyc(0, 3'b000, 0, 0, 0, 0, 0);
    chk("R6 set over clear", obs(), {8'h03, 1'b0, 1'b0});
    // R7 layout
    chk("R7 status byte", {status_o, 2'b00}, {8'h03, 2'b00});

    // R8 status write ignored
    cyc(0, 3'b000, 0, 0, 0, 0, 1);
    cyc(0, 3'b000, 0, 0, 0, 0, 0);
    chk("R8 status write", obs(), {8'h03, 1'b0, 1'b0});

    // R10 control change latency
    cyc(1, 3'b110, 0, 0, 0, 0, 0);
    chk("R10 ctl pin not yet", obs(), {8'h03, 1'b0, 1'b0});
    cyc(0, 3'b000, 0, 0, 0, 0, 0);
    chk("R10 ctl pin updated", obs(), {8'h03, 1'b1, 1'b0});
    // R2 merged: pin1 idle, flag1 routes to pin0
    cyc(1, 3'b010, 0, 0, 0, 0, 0);
    cyc(0, 3'b000, 0, 0, 0, 0, 0);
    chk("R2 merge flag1 to pin0", obs(), {8'h03, 1'b0, 1'b1});

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule